// File: doc/BRIEF.md
# Harris Corner Response Unit

This unit is the arithmetic heart of a streaming Harris corner detector. It sits between the convolution stages, which are built elsewhere, and has two independent streaming paths. The product path takes the horizontal and vertical gradient of one pixel and returns the three second-moment products: the two squares and the cross term. Those products go out to an external smoothing filter. The smoothed results come back on the score path, which turns them into the signed corner response for that pixel.

Both paths accept one pixel per clock whenever their valid input is high. There is no stall. Each path carries a start-of-frame and an end-of-frame marker next to its data. Markers and valid come out after the same fixed delay as the arithmetic, so exactly one result leaves for each pixel that enters, in the same raster order.

The design has no state machine. The only sequencing is the fixed-depth valid pipeline on each path. Each arithmetic stage updates only in the cycle in which a valid beat passes through it, and holds its value in every other cycle.

Top module: `harris_response`

## Requirements
- R1: For every accepted gradient pair (12-bit two's complement `g_ix` and `g_iy`), the product path outputs `p_xx = g_ix*g_ix`, `p_yy = g_iy*g_iy` and `p_xy = g_ix*g_iy`. Each product is exact and 24-bit signed.
- R2: A gradient beat captured at clock edge n appears on the product outputs with `p_valid` high right after edge n+2. Beats come out in input order, one output per input, and back-to-back input beats are all accepted.
- R3: For every accepted triple of 24-bit signed values a=`s_a`, b=`s_b`, c=`s_c`, the unsaturated score is (a*b - c*c) - ((3277*(a+b)*(a+b)) >>> 16). The shift is arithmetic, so the k term is rounded toward minus infinity.
- R4: `r_score` is the R3 value clamped to the 32-bit signed range: values above 2147483647 give 2147483647, and values below -2147483648 give -2147483648.
- R5: A score beat captured at edge n appears on `r_score` with `r_valid` high right after edge n+4. Beats come out in input order, one output per input, and one beat is accepted on every cycle that `s_valid` is high.
- R6: On each path, the start and end markers of a valid beat leave with that beat: `p_sof`/`p_eof` after 2 cycles, and `r_sof`/`r_eof` after 4 cycles.
- R7: A start or end marker presented while its path's valid input is low is ignored. No output marker is ever high while its path's output valid is low.
- R8: In any cycle where a path's output valid is low, that path's data outputs keep the value of the last valid beat they carried, or zero if no beat has left since reset.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| g_valid | input | 1 | Gradient beat present |
| g_sof | input | 1 | Gradient beat is the first pixel of a frame |
| g_eof | input | 1 | Gradient beat is the last pixel of a frame |
| g_ix | input | 12 | Horizontal gradient, signed |
| g_iy | input | 12 | Vertical gradient, signed |
| p_valid | output | 1 | Product beat present |
| p_sof | output | 1 | Product beat starts a frame |
| p_eof | output | 1 | Product beat ends a frame |
| p_xx | output | 24 | Square of horizontal gradient, signed |
| p_yy | output | 24 | Square of vertical gradient, signed |
| p_xy | output | 24 | Cross product of gradients, signed |
| s_valid | input | 1 | Smoothed-moment beat present |
| s_sof | input | 1 | Smoothed beat starts a frame |
| s_eof | input | 1 | Smoothed beat ends a frame |
| s_a | input | 24 | Smoothed horizontal square, signed |
| s_b | input | 24 | Smoothed vertical square, signed |
| s_c | input | 24 | Smoothed cross term, signed |
| r_valid | output | 1 | Score beat present |
| r_sof | output | 1 | Score beat starts a frame |
| r_eof | output | 1 | Score beat ends a frame |
| r_score | output | 32 | Saturated corner response, signed |

## Verification
Some properties are checked on every cycle by the assertions. These are the latency of valid and markers on both paths, the rule that no marker is ever high without valid, data holding still while valid is low, and squares never coming out negative. The arithmetic is checked only by the bench scenarios, which compare each beat against a 64-bit model. These scenarios cover the exact response formula with its floor-rounded k term, clamping at both ends of the 32-bit range, extreme gradient values, and markers offered with valid low.

// File: rtl/harris_response_pkg.sv
package harris_response_pkg;

    // Streaming side-band carried alongside every pixel
    typedef struct packed {
        logic vld;
        logic sof;
        logic eof;
    } hr_mark_t;

    // Fixed stage counts of the two paths
    localparam int PROD_LAT  = 2;
    localparam int SCORE_LAT = 4;

    // Sensitivity constant as numerator over a power of two (0.05 ~ 3277/65536)
    localparam int K_NUM   = 3277;
    localparam int K_SHIFT = 16;
    localparam int K_W     = 13;

endpackage

// File: rtl/hr_marker_delay.sv
module hr_marker_delay
    import harris_response_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  hr_mark_t              mark_in,
    output hr_mark_t [DEPTH-1:0]  taps
);

    hr_mark_t entry;

    // Markers only count when their beat is valid
    always_comb begin
        entry.vld = mark_in.vld;
        entry.sof = mark_in.vld & mark_in.sof;
        entry.eof = mark_in.vld & mark_in.eof;
    end

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_tap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    taps[i] <= '0;
                end else if (i == 0) begin
                    taps[i] <= entry;
                end else begin
                    taps[i] <= taps[(i > 0) ? i - 1 : 0];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/hr_grad_products.sv
module hr_grad_products #(
    parameter int GRAD_W = 12,
    localparam int PROD_W = 2 * GRAD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_in,
    input  logic                     en_mul,
    input  logic signed [GRAD_W-1:0] ix,
    input  logic signed [GRAD_W-1:0] iy,
    output logic signed [PROD_W-1:0] xx,
    output logic signed [PROD_W-1:0] yy,
    output logic signed [PROD_W-1:0] xy
);

    logic signed [GRAD_W-1:0] ix_q;
    logic signed [GRAD_W-1:0] iy_q;

    // Stage 1: capture gradients
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ix_q <= '0;
            iy_q <= '0;
        end else if (en_in) begin
            ix_q <= ix;
            iy_q <= iy;
        end
    end

    // Stage 2: full-width signed products
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xx <= '0;
            yy <= '0;
            xy <= '0;
        end else if (en_mul) begin
            xx <= PROD_W'(ix_q) * PROD_W'(ix_q);
            yy <= PROD_W'(iy_q) * PROD_W'(iy_q);
            xy <= PROD_W'(ix_q) * PROD_W'(iy_q);
        end
    end

endmodule

// File: rtl/hr_score_pipe.sv
module hr_score_pipe
    import harris_response_pkg::*;
#(
    parameter int SUM_W = 24,
    parameter int OUT_W = 32,
    localparam int AB_W  = 2 * SUM_W,
    localparam int TR_W  = SUM_W + 1,
    localparam int TR2_W = 2 * TR_W,
    localparam int DET_W = AB_W + 1,
    localparam int KP_W  = TR2_W + K_W,
    localparam int RES_W = KP_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SCORE_LAT-1:0]    en,
    input  logic signed [SUM_W-1:0] a,
    input  logic signed [SUM_W-1:0] b,
    input  logic signed [SUM_W-1:0] c,
    output logic signed [OUT_W-1:0] score
);

    localparam logic signed [K_W-1:0]   K_VAL  = K_W'(K_NUM);
    localparam logic signed [RES_W-1:0] SAT_HI = {{(RES_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
    localparam logic signed [RES_W-1:0] SAT_LO = {{(RES_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

    logic signed [AB_W-1:0]  ab_q;
    logic signed [AB_W-1:0]  cc_q;
    logic signed [TR_W-1:0]  tr_q;
    logic signed [DET_W-1:0] det_q;
    logic signed [DET_W-1:0] det_d;
    logic signed [TR2_W-1:0] tr2_q;
    logic signed [KP_W-1:0]  kt_q;
    logic signed [RES_W-1:0] diff;

    // Stage 1: products and trace
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ab_q <= '0;
            cc_q <= '0;
            tr_q <= '0;
        end else if (en[0]) begin
            ab_q <= AB_W'(a) * AB_W'(b);
            cc_q <= AB_W'(c) * AB_W'(c);
            tr_q <= TR_W'(a) + TR_W'(b);
        end
    end

    // Stage 2: determinant and trace squared
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
            tr2_q <= '0;
        end else if (en[1]) begin
            det_q <= DET_W'(ab_q) - DET_W'(cc_q);
            tr2_q <= TR2_W'(tr_q) * TR2_W'(tr_q);
        end
    end

    // Stage 3: scale trace term by k, carry determinant along
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_d <= '0;
            kt_q  <= '0;
        end else if (en[2]) begin
            det_d <= det_q;
            kt_q  <= (KP_W'(tr2_q) * KP_W'(K_VAL)) >>> K_SHIFT;
        end
    end

    assign diff = RES_W'(det_d) - RES_W'(kt_q);

    // Stage 4: subtract and clamp
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            score <= '0;
        end else if (en[3]) begin
            if (diff > SAT_HI) begin
                score <= SAT_HI[OUT_W-1:0];
            end else if (diff < SAT_LO) begin
                score <= SAT_LO[OUT_W-1:0];
            end else begin
                score <= diff[OUT_W-1:0];
            end
        end
    end

endmodule

// File: rtl/harris_response.sv
module harris_response
    import harris_response_pkg::*;
#(
    parameter int GRAD_W = 12,
    parameter int SUM_W  = 24,
    parameter int OUT_W  = 32,
    localparam int PROD_W = 2 * GRAD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     g_valid,
    input  logic                     g_sof,
    input  logic                     g_eof,
    input  logic signed [GRAD_W-1:0] g_ix,
    input  logic signed [GRAD_W-1:0] g_iy,
    output logic                     p_valid,
    output logic                     p_sof,
    output logic                     p_eof,
    output logic signed [PROD_W-1:0] p_xx,
    output logic signed [PROD_W-1:0] p_yy,
    output logic signed [PROD_W-1:0] p_xy,
    input  logic                     s_valid,
    input  logic                     s_sof,
    input  logic                     s_eof,
    input  logic signed [SUM_W-1:0]  s_a,
    input  logic signed [SUM_W-1:0]  s_b,
    input  logic signed [SUM_W-1:0]  s_c,
    output logic                     r_valid,
    output logic                     r_sof,
    output logic                     r_eof,
    output logic signed [OUT_W-1:0]  r_score
);

    hr_mark_t                    g_mark;
    hr_mark_t                    s_mark;
    hr_mark_t [PROD_LAT-1:0]     g_taps;
    hr_mark_t [SCORE_LAT-1:0]    s_taps;
    logic     [SCORE_LAT-1:0]    s_en;

    assign g_mark = '{vld: g_valid, sof: g_sof, eof: g_eof};
    assign s_mark = '{vld: s_valid, sof: s_sof, eof: s_eof};

    // Product path
    hr_marker_delay #(.DEPTH(PROD_LAT)) u_gmark (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark_in (g_mark),
        .taps    (g_taps)
    );

    hr_grad_products #(.GRAD_W(GRAD_W)) u_prod (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_in  (g_valid),
        .en_mul (g_taps[0].vld),
        .ix     (g_ix),
        .iy     (g_iy),
        .xx     (p_xx),
        .yy     (p_yy),
        .xy     (p_xy)
    );

    assign p_valid = g_taps[PROD_LAT-1].vld;
    assign p_sof   = g_taps[PROD_LAT-1].sof;
    assign p_eof   = g_taps[PROD_LAT-1].eof;

    // Score path: each stage enabled by the valid bit entering it
    hr_marker_delay #(.DEPTH(SCORE_LAT)) u_smark (
        .clk     (clk),
        .rst_n   (rst_n),
        .mark_in (s_mark),
        .taps    (s_taps)
    );

    genvar k;
    generate
        for (k = 0; k < SCORE_LAT; k++) begin : g_en
            if (k == 0) begin : g_first
                assign s_en[k] = s_valid;
            end else begin : g_rest
                assign s_en[k] = s_taps[k-1].vld;
            end
        end
    endgenerate

    hr_score_pipe #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_score (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_en),
        .a     (s_a),
        .b     (s_b),
        .c     (s_c),
        .score (r_score)
    );

    assign r_valid = s_taps[SCORE_LAT-1].vld;
    assign r_sof   = s_taps[SCORE_LAT-1].sof;
    assign r_eof   = s_taps[SCORE_LAT-1].eof;

endmodule

// File: rtl/harris_response_chk.sv
module harris_response_chk #(
    parameter int PROD_W = 24,
    parameter int OUT_W  = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     g_valid,
    input logic                     g_sof,
    input logic                     g_eof,
    input logic                     s_valid,
    input logic                     s_sof,
    input logic                     s_eof,
    input logic                     p_valid,
    input logic                     p_sof,
    input logic                     p_eof,
    input logic signed [PROD_W-1:0] p_xx,
    input logic signed [PROD_W-1:0] p_yy,
    input logic signed [PROD_W-1:0] p_xy,
    input logic                     r_valid,
    input logic                     r_sof,
    input logic                     r_eof,
    input logic signed [OUT_W-1:0]  r_score
);

    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
        end else if (since_rst != 3'd7) begin
            since_rst <= since_rst + 3'd1;
        end
    end

    AST_PROD_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |-> (p_valid == $past(g_valid, 2))); // R2

    AST_SCORE_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> (r_valid == $past(s_valid, 4))); // R5

    AST_PROD_MARK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2) |-> ({p_sof, p_eof} == $past({g_sof & g_valid, g_eof & g_valid}, 2))); // R6

    AST_SCORE_MARK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd4) |-> ({r_sof, r_eof} == $past({s_sof & s_valid, s_eof & s_valid}, 4))); // R6

    AST_PROD_MARK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (p_sof || p_eof) |-> p_valid); // R7

    AST_SCORE_MARK_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        (r_sof || r_eof) |-> r_valid); // R7

    AST_PROD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !p_valid |-> ($stable(p_xx) && $stable(p_yy) && $stable(p_xy))); // R8

    AST_SCORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !r_valid |-> $stable(r_score)); // R8

    AST_SQUARE_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
        p_valid |-> (!p_xx[PROD_W-1] && !p_yy[PROD_W-1])); // R1

endmodule

bind harris_response harris_response_chk #(.PROD_W(PROD_W), .OUT_W(OUT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .g_valid (g_valid),
    .g_sof   (g_sof),
    .g_eof   (g_eof),
    .s_valid (s_valid),
    .s_sof   (s_sof),
    .s_eof   (s_eof),
    .p_valid (p_valid),
    .p_sof   (p_sof),
    .p_eof   (p_eof),
    .p_xx    (p_xx),
    .p_yy    (p_yy),
    .p_xy    (p_xy),
    .r_valid (r_valid),
    .r_sof   (r_sof),
    .r_eof   (r_eof),
    .r_score (r_score)
);

// File: tb/harris_response_test.sv
module harris_response_test;

    localparam time CLK_PER = 20ns;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               g_valid = 1'b0, g_sof = 1'b0, g_eof = 1'b0;
    logic signed [11:0] g_ix = '0, g_iy = '0;
    logic               p_valid, p_sof, p_eof;
    logic signed [23:0] p_xx, p_yy, p_xy;
    logic               s_valid = 1'b0, s_sof = 1'b0, s_eof = 1'b0;
    logic signed [23:0] s_a = '0, s_b = '0, s_c = '0;
    logic               r_valid, r_sof, r_eof;
    logic signed [31:0] r_score;

    always #(CLK_PER/2) clk = ~clk;

    harris_response uut (
        .clk(clk), .rst_n(rst_n),
        .g_valid(g_valid), .g_sof(g_sof), .g_eof(g_eof), .g_ix(g_ix), .g_iy(g_iy),
        .p_valid(p_valid), .p_sof(p_sof), .p_eof(p_eof),
        .p_xx(p_xx), .p_yy(p_yy), .p_xy(p_xy),
        .s_valid(s_valid), .s_sof(s_sof), .s_eof(s_eof), .s_a(s_a), .s_b(s_b), .s_c(s_c),
        .r_valid(r_valid), .r_sof(r_sof), .r_eof(r_eof), .r_score(r_score)
    );

    typedef struct {
        bit     gv, gs, ge;
        longint ix, iy;
        bit     sv, ss, se;
        longint a, b, c;
    } beat_t;

    beat_t  hist [8];
    int     t = 8;
    int     n_chk = 0;
    int     n_bad = 0;
    bit     finished = 1'b0;
    longint hold_xx = 0, hold_yy = 0, hold_xy = 0, hold_sc = 0;

    function automatic longint model_score(longint a, longint b, longint c);
        longint det, tr, kt, r;
        det = a * b - c * c;
        tr  = a + b;
        kt  = (tr * tr * 64'sd3277) >>> 16;
        r   = det - kt;
        if (r > 64'sd2147483647)  r = 64'sd2147483647;
        if (r < -64'sd2147483648) r = -64'sd2147483648;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (t=%0d)", req, what, act, exp, t);
        end
    endtask

    task automatic check_outputs();
        beat_t e2, e4;
        e2 = hist[(t - 2) % 8];
        e4 = hist[(t - 4) % 8];
        if (e2.gv) begin
            hold_xx = e2.ix * e2.ix;
            hold_yy = e2.iy * e2.iy;
            hold_xy = e2.ix * e2.iy;
        end
        if (e4.sv) hold_sc = model_score(e4.a, e4.b, e4.c);
        chk("R2", "p_valid", longint'(p_valid), longint'(e2.gv));
        chk("R6/R7", "p_sof", longint'(p_sof), longint'(e2.gv & e2.gs));
        chk("R6/R7", "p_eof", longint'(p_eof), longint'(e2.gv & e2.ge));
        chk("R1/R8", "p_xx", longint'(p_xx), hold_xx);
        chk("R1/R8", "p_yy", longint'(p_yy), hold_yy);
        chk("R1/R8", "p_xy", longint'(p_xy), hold_xy);
        chk("R5", "r_valid", longint'(r_valid), longint'(e4.sv));
        chk("R6/R7", "r_sof", longint'(r_sof), longint'(e4.sv & e4.ss));
        chk("R6/R7", "r_eof", longint'(r_eof), longint'(e4.sv & e4.se));
        chk("R3/R4/R8", "r_score", longint'(r_score), hold_sc);
    endtask

    task automatic step(input beat_t bt);
        @(negedge clk);
        check_outputs();
        g_valid = bt.gv; g_sof = bt.gs; g_eof = bt.ge;
        g_ix = 12'(bt.ix); g_iy = 12'(bt.iy);
        s_valid = bt.sv; s_sof = bt.ss; s_eof = bt.se;
        s_a = 24'(bt.a); s_b = 24'(bt.b); s_c = 24'(bt.c);
        hist[t % 8] = bt;
        t++;
    endtask

    function automatic beat_t mk(bit gv, bit gs, bit ge, longint ix, longint iy,
                                 bit sv, bit ss, bit se, longint a, longint b, longint c);
        beat_t bt;
        bt.gv = gv; bt.gs = gs; bt.ge = ge; bt.ix = ix; bt.iy = iy;
        bt.sv = sv; bt.ss = ss; bt.se = se; bt.a = a; bt.b = b; bt.c = c;
        return bt;
    endfunction

    function automatic longint rs(int bits);
        longint v;
        v = longint'($urandom) & ((64'sd1 <<< bits) - 1);
        if (v >= (64'sd1 <<< (bits - 1))) v = v - (64'sd1 <<< bits);
        return v;
    endfunction

    initial begin
        #(CLK_PER * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd20240611);
        for (int i = 0; i < 8; i++) hist[i] = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R9: reset holds outputs at zero even with active inputs
        g_valid = 1'b1; g_sof = 1'b1; g_ix = 12'sd100; s_valid = 1'b1; s_eof = 1'b1; s_a = 24'sd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9", "reset outputs", longint'({p_valid, p_sof, p_eof, r_valid, r_sof, r_eof}), 0);
        chk("R9", "reset p_xx", longint'(p_xx), 0);
        chk("R9", "reset r_score", longint'(r_score), 0);
        g_valid = 1'b0; g_sof = 1'b0; g_ix = '0; s_valid = 1'b0; s_eof = 1'b0; s_a = '0;
        rst_n = 1'b1;

        // Directed corners, back to back (R1, R3, R4, R5, R6)
        step(mk(1, 1, 0, -2048, 2047, 1, 1, 0, 8388607, 8388607, 0));     // R4 positive clamp
        step(mk(1, 0, 0, -2048, -2048, 1, 0, 0, 0, 0, 8388607));          // R4 negative clamp
        step(mk(1, 0, 0, 2047, 2047, 1, 0, 0, -8388608, -8388608, -8388608));
        step(mk(1, 0, 0, 0, -1, 1, 0, 0, 1, 1, 0));                       // R3 floor of k term
        step(mk(1, 0, 1, -1, 1, 1, 0, 1, 1000, 2000, 300));
        step(mk(1, 0, 0, 3, -7, 1, 0, 0, -1, 0, 0));                      // R3 negative trace
        step(mk(1, 0, 0, 5, 5, 1, 0, 0, 46341, 46341, 0));                // near clamp edge
        // R7: markers with valid low are ignored, R8 data holds
        step(mk(0, 1, 1, 99, 99, 0, 1, 1, 777, 888, 999));
        step(mk(0, 1, 0, -5, 4, 0, 0, 1, 12, 13, 14));
        for (int i = 0; i < 6; i++) step(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        // Random traffic with gaps, frames and mixed magnitudes
        for (int i = 0; i < 3000; i++) begin
            beat_t bt;
            int    mode;
            mode = int'($urandom % 3);
            bt = mk(($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                    rs(12), rs(12),
                    ($urandom % 4) != 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
                    0, 0, 0);
            if (mode == 0) begin
                bt.a = rs(24); bt.b = rs(24); bt.c = rs(24);
            end else if (mode == 1) begin
                bt.a = rs(16); bt.b = rs(16); bt.c = rs(16);
            end else begin
                bt.a = rs(10) & 64'h1ff; bt.b = rs(10) & 64'h1ff; bt.c = rs(8);
            end
            step(bt);
        end
        for (int i = 0; i < 6; i++) step(mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0));

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule